// File: doc/BRIEF.md
# SCSI Message-In Byte Assembler

This block sits behind the byte path of a parallel SCSI initiator. While the target holds the bus in the message-in phase, the bus interface passes each received byte in with a one-cycle valid strobe. The block gathers those bytes into one complete target message in a small local buffer. It then reports that the message is ready, together with the stored bytes and their count. Deciding what the message means, and driving the REQ/ACK handshake on the bus, are left to the surrounding logic.

Two message shapes are recognised. A lead byte of 0x01 opens an extended message. The next byte gives the number of data bytes that follow, and a value of zero stands for 256. Any other lead byte is a complete one-byte message. If the target leaves the message-in phase after the message has started but before it is complete, the block raises a protocol-error flag. Counted data that does not fit in the buffer is dropped, and an overflow flag records the loss.

A phase-entry pulse, raised each time the bus enters message-in, returns the reader to its idle state. The consumer can raise a clear pulse to free the buffer for the next message without a phase change.

Top module: `msgin_assembler`

## Requirements
- R1: After reset, state_o is 0, ready_o, err_o and ovf_o are low, and len_o is 0.
- R2: A cycle with phase_entry_i or clear_i high makes the next state_o 0 (idle), drops ready_o, sets len_o to 0 and clears err_o and ovf_o. This takes priority over any byte offered in that cycle.
- R3: A byte is taken only when byte_valid_i is high and phase_i equals 3'b111 (bit2 MSG, bit1 C/D, bit0 I/O all high). Bytes offered under any other phase leave len_o, the buffer and state_o unchanged.
- R4: In idle, an accepted byte other than 0x01 is stored at buffer index 0 (buf_o[7:0]). In the next cycle len_o is 1 and state_o is 3 (ready, ready_o high). Taking a lead byte also clears ovf_o.
- R5: In idle, an accepted byte 0x01 is stored at index 0 and moves state_o to 2 (length). The next accepted byte is stored at index 1 as the length, and state_o becomes 1 (data) with len_o 2.
- R6: In state 1, each accepted byte is stored at index len_o (buf_o bits 8*i+7 down to 8*i) and len_o increments. After the number of bytes the length gave, state_o becomes 3, with len_o equal to 2 plus that number.
- R7: A length byte of 0 means 256 data bytes. The message completes only after all 256 have been taken.
- R8: While state_o is 3, ready_o stays high and len_o and buf_o stay unchanged, with any offered byte ignored, until phase_entry_i or clear_i.
- R9: If phase_i differs from 3'b111 while state_o is 1 or 2, err_o is set in the next cycle and state_o returns to 0, with len_o unchanged. err_o stays set until phase_entry_i or clear_i.
- R10: A data byte that arrives while len_o equals 16 (buffer full) is dropped and sets ovf_o. len_o never exceeds 16, and the message still completes on its count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 3 | Current bus phase {MSG, C/D, I/O} |
| phase_entry_i | input | 1 | Pulse when the bus enters message-in |
| clear_i | input | 1 | Pulse from the consumer to release the message |
| byte_valid_i | input | 1 | byte_i carries a received byte this cycle |
| byte_i | input | 8 | Received message byte |
| state_o | output | 2 | Reader state: 0 idle, 1 data, 2 length, 3 ready |
| ready_o | output | 1 | A complete message is held |
| len_o | output | 5 | Number of bytes stored |
| buf_o | output | 128 | Stored bytes, index i at bits 8*i+7:8*i |
| err_o | output | 1 | Phase left before the message completed |
| ovf_o | output | 1 | Counted data was dropped for lack of space |

## Verification
The bench targets a length byte of zero. A design that reads it literally would finish after the length byte, while a correct one waits for 256 data bytes and truncates them. It sends lengths above the buffer capacity, where a design that fails to guard the write index would wrap around and overwrite the lead byte or let len_o pass 16. Phase changes are placed both in the length state and in the data state; a reader that checks only one of them would miss the error or keep storing. Bytes sent while the message is ready, and a phase-entry pulse in the same cycle as a valid byte, catch designs that overwrite a finished message or let the byte win over the restart.

// File: rtl/msgin_pkg.sv
`timescale 1ns/1ps
package msgin_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_LEN  = 2'd2,
    ST_DONE = 2'd3
  } rx_state_e;

  localparam logic [2:0] PHASE_MSG_IN  = 3'b111;
  localparam logic [7:0] EXT_LEAD      = 8'h01;
  localparam int         LEN_ZERO_SPAN = 256;

endpackage

// File: rtl/msgin_rst_sync.sv
`timescale 1ns/1ps
module msgin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/msgin_fsm.sv
`timescale 1ns/1ps
module msgin_fsm
  import msgin_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart_i,
  input  logic       in_phase_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       full_i,
  output rx_state_e  state_o,
  output logic       start_o,
  output logic       wr_o,
  output logic       err_o,
  output logic       ovf_o
);
  rx_state_e        state_q, state_d;
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             err_q, err_d;
  logic             ovf_q, ovf_d;
  logic             take;
  logic             upd_en;

  assign take = byte_valid_i && in_phase_i;

  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    err_d    = err_q;
    ovf_d    = ovf_q;
    start_o  = 1'b0;
    wr_o     = 1'b0;
    if (restart_i) begin
      state_d  = ST_IDLE;
      remain_d = '0;
      err_d    = 1'b0;
      ovf_d    = 1'b0;
    end else if ((state_q == ST_LEN || state_q == ST_DATA) && !in_phase_i) begin
      state_d = ST_IDLE;
      err_d   = 1'b1;
    end else if (take) begin
      unique case (state_q)
        ST_IDLE: begin
          start_o = 1'b1;
          ovf_d   = 1'b0;
          state_d = (byte_i == EXT_LEAD) ? ST_LEN : ST_DONE;
        end
        ST_LEN: begin
          wr_o     = 1'b1;
          remain_d = (byte_i == 8'h00) ? CNT_W'(LEN_ZERO_SPAN) : CNT_W'(byte_i);
          state_d  = ST_DATA;
        end
        ST_DATA: begin
          if (full_i) ovf_d = 1'b1;
          else        wr_o  = 1'b1;
          remain_d = remain_q - CNT_W'(1);
          if (remain_q == CNT_W'(1)) state_d = ST_DONE;
        end
        default: begin
          state_d = ST_DONE;
        end
      endcase
    end
  end

  assign upd_en = restart_i || take || (state_q == ST_LEN) || (state_q == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      err_q    <= 1'b0;
      ovf_q    <= 1'b0;
    end else if (upd_en) begin
      state_q  <= state_d;
      remain_q <= remain_d;
      err_q    <= err_d;
      ovf_q    <= ovf_d;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/msgin_buf.sv
`timescale 1ns/1ps
module msgin_buf #(
  parameter int DEPTH = 16,
  parameter int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               start_i,
  input  logic               wr_i,
  input  logic [7:0]         data_i,
  output logic [LEN_W-1:0]   len_o,
  output logic               full_o,
  output logic [DEPTH*8-1:0] flat_o
);
  logic [LEN_W-1:0] len_q, len_d;
  logic             len_en;
  logic             push;

  assign full_o = (len_q == LEN_W'(DEPTH));
  assign push   = wr_i && !full_o && !clr_i;

  always_comb begin
    len_d  = len_q;
    len_en = 1'b0;
    if (clr_i) begin
      len_d  = '0;
      len_en = 1'b1;
    end else if (start_i) begin
      len_d  = LEN_W'(1);
      len_en = 1'b1;
    end else if (push) begin
      len_d  = len_q + LEN_W'(1);
      len_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_en) len_q <= len_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [7:0] slot_q;
    logic       slot_we;
    if (g == 0) begin : g_head
      assign slot_we = (start_i && !clr_i) || (push && len_q == '0);
    end else begin : g_body
      assign slot_we = push && (len_q == LEN_W'(g));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_we) slot_q <= data_i;
    end
    assign flat_o[g*8 +: 8] = slot_q;
  end

  assign len_o = len_q;
endmodule

// File: rtl/msgin_assembler.sv
`timescale 1ns/1ps
module msgin_assembler
  import msgin_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(LEN_ZERO_SPAN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         phase_i,
  input  logic               phase_entry_i,
  input  logic               clear_i,
  input  logic               byte_valid_i,
  input  logic [7:0]         byte_i,
  output logic [1:0]         state_o,
  output logic               ready_o,
  output logic [LEN_W-1:0]   len_o,
  output logic [DEPTH*8-1:0] buf_o,
  output logic               err_o,
  output logic               ovf_o
);
  logic      rst_core_n;
  logic      restart;
  logic      in_phase;
  logic      start;
  logic      wr;
  logic      full;
  rx_state_e state;

  assign restart  = phase_entry_i || clear_i;
  assign in_phase = (phase_i == PHASE_MSG_IN);

  msgin_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_core_n)
  );

  msgin_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .restart_i   (restart),
    .in_phase_i  (in_phase),
    .byte_valid_i(byte_valid_i),
    .byte_i      (byte_i),
    .full_i      (full),
    .state_o     (state),
    .start_o     (start),
    .wr_o        (wr),
    .err_o       (err_o),
    .ovf_o       (ovf_o)
  );

  msgin_buf #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_buf (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clr_i  (restart),
    .start_i(start),
    .wr_i   (wr),
    .data_i (byte_i),
    .len_o  (len_o),
    .full_o (full),
    .flat_o (buf_o)
  );

  assign state_o = state;
  assign ready_o = (state == ST_DONE);
endmodule

// File: rtl/msgin_assembler_chk.sv
`timescale 1ns/1ps
module msgin_assembler_chk #(
  parameter int DEPTH = 16,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         phase_i,
  input logic               phase_entry_i,
  input logic               clear_i,
  input logic               byte_valid_i,
  input logic [7:0]         byte_i,
  input logic [1:0]         state_o,
  input logic               ready_o,
  input logic [LEN_W-1:0]   len_o,
  input logic [DEPTH*8-1:0] buf_o,
  input logic               err_o,
  input logic               ovf_o
);
  logic rs;
  logic take;
  assign rs   = phase_entry_i || clear_i;
  assign take = byte_valid_i && (phase_i == 3'b111);

  assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rs |=> (state_o == 2'd0 && !ready_o && len_o == '0 && !err_o && !ovf_o));

  assert_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !rs && (state_o == 2'd0 || state_o == 2'd3))
      |=> ($stable(len_o) && $stable(state_o)));

  assert_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0 && take && byte_i != 8'h01 && !rs)
      |=> (ready_o && len_o == LEN_W'(1) && buf_o[7:0] == $past(byte_i)));

  assert_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && take && !rs)
      |=> (state_o == 2'd1 && len_o == LEN_W'(2) && buf_o[15:8] == $past(byte_i)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !rs) |=> (ready_o && $stable(len_o) && $stable(buf_o)));

  assert_phase_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 2'd1 || state_o == 2'd2) && phase_i != 3'b111 && !rs)
      |=> (err_o && state_o == 2'd0 && $stable(len_o)));

  assert_len_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    len_o <= LEN_W'(DEPTH));

  assert_ovf_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> (len_o == LEN_W'(DEPTH)));
endmodule

bind msgin_assembler msgin_assembler_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .phase_i      (phase_i),
  .phase_entry_i(phase_entry_i),
  .clear_i      (clear_i),
  .byte_valid_i (byte_valid_i),
  .byte_i       (byte_i),
  .state_o      (state_o),
  .ready_o      (ready_o),
  .len_o        (len_o),
  .buf_o        (buf_o),
  .err_o        (err_o),
  .ovf_o        (ovf_o)
);

// File: tb/msgin_assembler_tb.sv
`timescale 1ns/1ps
module msgin_assembler_tb;
  localparam int DEPTH = 16;
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [2:0]         phase = 3'b111;
  logic               pentry = 1'b0;
  logic               clr = 1'b0;
  logic               bv = 1'b0;
  logic [7:0]         bdat = 8'h00;
  logic [1:0]         state_o;
  logic               ready_o;
  logic [LEN_W-1:0]   len_o;
  logic [DEPTH*8-1:0] buf_o;
  logic               err_o;
  logic               ovf_o;

  always #2.5 clk = ~clk;

  msgin_assembler #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .phase_i(phase), .phase_entry_i(pentry),
    .clear_i(clr), .byte_valid_i(bv), .byte_i(bdat), .state_o(state_o),
    .ready_o(ready_o), .len_o(len_o), .buf_o(buf_o), .err_o(err_o), .ovf_o(ovf_o)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference model
  int         m_st;
  int         m_rem;
  bit         m_err;
  bit         m_ovf;
  logic [7:0] m_q[$];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (pentry || clr) begin
      m_st = 0; m_rem = 0; m_err = 0; m_ovf = 0; m_q.delete();
    end else if ((m_st == 1 || m_st == 2) && phase != 3'b111) begin
      m_st = 0; m_err = 1;
    end else if (bv && phase == 3'b111) begin
      case (m_st)
        0: begin
          m_q.delete(); m_q.push_back(bdat); m_ovf = 0;
          m_st = (bdat == 8'h01) ? 2 : 3;
        end
        2: begin
          m_q.push_back(bdat);
          m_rem = (bdat == 8'h00) ? 256 : int'(bdat);
          m_st = 1;
        end
        1: begin
          if (m_q.size() < DEPTH) m_q.push_back(bdat);
          else m_ovf = 1;
          m_rem--;
          if (m_rem == 0) m_st = 3;
        end
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_rem = 0; m_err = 0; m_ovf = 0; m_q.delete();
    end else begin
      model_step();
    end
    #1;
    if (rst_n && !done) begin
      chk(cur_req, "state", int'(state_o), m_st);
      chk(cur_req, "ready", int'(ready_o), int'(m_st == 3));
      chk(cur_req, "len", int'(len_o), m_q.size());
      chk(cur_req, "err", int'(err_o), int'(m_err));
      chk(cur_req, "ovf", int'(ovf_o), int'(m_ovf));
      for (int i = 0; i < m_q.size(); i++)
        chk(cur_req, "byte", int'(buf_o[i*8 +: 8]), int'(m_q[i]));
    end
  end

  task automatic put(input bit v, input logic [7:0] b, input logic [2:0] ph,
                     input bit pe, input bit cl);
    @(negedge clk);
    bv = v; bdat = b; phase = ph; pentry = pe; clr = cl;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(0, 8'h00, phase, 0, 0);
  endtask

  task automatic send(input logic [7:0] b);
    put(1, b, 3'b111, 0, 0);
  endtask

  task automatic enter();
    put(0, 8'h00, 3'b111, 1, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    @(negedge clk);
    cur_req = "R1";
    chk("R1", "state", int'(state_o), 0);
    chk("R1", "len", int'(len_o), 0);
    chk("R1", "flags", int'({ready_o, err_o, ovf_o}), 0);

    cur_req = "R2"; enter(); idle(1);

    cur_req = "R4"; send(8'h00); idle(1);
    @(negedge clk);
    chk("R4", "ready", int'(ready_o), 1);
    chk("R4", "byte0", int'(buf_o[7:0]), 0);
    cur_req = "R8"; send(8'h55); send(8'h01); idle(2);
    chk("R8", "len", int'(len_o), 1);
    cur_req = "R2"; put(0, 8'h00, 3'b111, 0, 1); idle(1);

    cur_req = "R3";
    put(1, 8'h07, 3'b011, 0, 0); put(1, 8'h04, 3'b110, 0, 0);
    put(0, 8'h09, 3'b111, 0, 0); idle(2);
    chk("R3", "len", int'(len_o), 0);
    enter();

    cur_req = "R5"; send(8'h01); send(8'h03);
    cur_req = "R6"; send(8'h01); idle(2); send(8'h19); put(0, 8'h00, 3'b111, 0, 0);
    send(8'h0F); idle(2);
    chk("R6", "len", int'(len_o), 5);
    chk("R6", "ready", int'(ready_o), 1);

    cur_req = "R9"; enter(); send(8'h01); send(8'h05); send(8'hAA);
    put(0, 8'h00, 3'b110, 0, 0); idle(2);
    chk("R9", "err", int'(err_o), 1);
    put(1, 8'hBB, 3'b111, 1, 0); idle(1);
    cur_req = "R9"; send(8'h01); put(1, 8'h02, 3'b000, 0, 0); idle(2);
    put(0, 8'h00, 3'b111, 0, 0);
    send(8'h23); idle(1);

    cur_req = "R7"; enter(); send(8'h01); send(8'h00);
    for (int i = 0; i < 255; i++) send(8'(i + 3));
    idle(1);
    chk("R7", "ready_before_last", int'(ready_o), 0);
    send(8'hEE); idle(1);
    chk("R7", "ready", int'(ready_o), 1);
    chk("R10", "ovf", int'(ovf_o), 1);
    chk("R10", "len", int'(len_o), 16);

    cur_req = "R10"; put(0, 8'h00, 3'b111, 0, 1);
    send(8'h01); send(8'h20);
    for (int i = 0; i < 32; i++) send(8'(8'hC0 + i));
    idle(2);
    cur_req = "R4"; put(0, 8'h00, 3'b111, 0, 1); send(8'h80); idle(1);
    cur_req = "R2"; send(8'h01); put(1, 8'h04, 3'b111, 0, 1); idle(2);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule